// File: doc/BRIEF.md
# SPI Serial Flash Slave Front End

This block is the digital front end of a byte-wide serial flash that answers as an SPI slave (clock idle low, mode 0). The serial clock, chip select, data input and hold pins are brought into the system clock domain. Input bits are taken on the rising serial-clock edge, and output bits are updated on the falling edge. Each frame starts with an 8-bit opcode, sent MSB first. Commands that need an address follow it with three address bytes, also MSB first. Only the low bits of the address that fit the array are kept.

The block executes read, page program, sector erase, bulk erase and status read. The storage is a register memory. It is smaller than a real device, but it keeps the split into pages and sectors. A program or an erase takes effect when chip select rises. The block then raises a busy flag for a programmable number of system clocks, in place of real cell timing. It stays busy while it is deselected. After power-up the block accepts nothing until it has seen chip select high and then low. A hold input freezes the serial transfer without ending the command in progress.

Top module: `spi_flash_slave`

## Requirements
- R1: After reset, no byte is decoded and `spi_miso_oe` stays 0 until `spi_cs_n` has been seen high and then low. A frame clocked in while chip select was held low from reset has no effect on the memory.
- R2: `spi_miso_oe` is 0 whenever `spi_cs_n` is high. It is 1 during a selected frame that is not on hold.
- R3: Opcode 0x03, followed by a 24-bit address, returns the memory bytes from that address onward. The bytes come MSB first, one bit per falling edge. The address counts up through successive bytes and wraps from the last byte of the array to byte 0.
- R4: Opcode 0x05 returns the status byte for as long as it is clocked. Bit 0 is the busy flag, and bits 7:1 read 0.
- R5: Opcode 0x02, followed by an address and 1 or more data bytes, programs one page. Each stored byte becomes the old value AND the data. Bytes past the page end wrap to the start of the same page. When a page offset is written twice in one frame, the later byte is used.
- R6: Opcode 0xD8, followed by an address, sets every byte of the sector that holds the address to 0xFF. The other sector is unchanged.
- R7: Opcode 0xC7 sets every byte of the array to 0xFF.
- R8: A program or erase takes effect only if chip select rises after a whole number of bytes. A program also needs at least one data byte. An erase is cancelled if any byte follows its last required byte.
- R9: Each accepted program or erase sets busy for `BUSY_CYCLES` clocks. A program or erase opcode received while busy is ignored.
- R10: An unknown opcode causes every later byte of the same frame to be ignored.
- R11: While `spi_hold_n` is low, serial-clock edges are ignored and `spi_miso_oe` is 0. The instruction resumes when hold is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Hold, active low; pauses the transfer |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; 0 means high impedance |

## Verification
Two things can meet in one cycle: a program or erase opcode being decoded, and the busy flag from the previous commit still being set. The bench provokes this by sending a second program at once after a first one has committed. It then judges the result at the ports. A status read must show busy as 1. After busy clears, a read-back must show that only the first program changed the memory. Randomised programs with wrapping page offsets, and reads that cross the top of the array, are compared against a bench model of the memory.

// File: rtl/spi_flash_pkg.sv
// Package: opcodes and command-state type shared by the flash front end.
// Assumes one opcode byte per frame, MSB first.
package spi_flash_pkg;
    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_SERASE = 8'hD8;
    localparam logic [7:0] OPC_BERASE = 8'hC7;
    localparam logic [7:0] OPC_STATUS = 8'h05;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_READ,
        ST_PROG,
        ST_STATUS,
        ST_ERASE_END,
        ST_DISCARD
    } cmd_state_t;
endpackage

// File: rtl/spi_flash_bitio.sv
// Serial bit engine. Synchronises the SPI pins to clk and finds the clock
// edges. Collects bytes on rising edges and shifts out tx_byte on falling
// edges. Enforces the arming rule after power-up and the hold pause.
// Assumes the serial clock runs well below clk/4.
module spi_flash_bitio (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    input  logic       hold_n_i,
    input  logic [7:0] tx_byte,
    output logic       byte_valid,
    output logic [7:0] rx_byte,
    output logic       frame_end,
    output logic       end_aligned,
    output logic       miso,
    output logic       miso_oe
);
    logic sclk_m, sclk_s, cs_m, cs_s, mosi_m, mosi_s, hold_m, hold_s;
    logic sclk_d, cs_d;
    logic seen_high, armed;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic active, sclk_rise, sclk_fall;

    assign active    = armed & ~cs_s & hold_s;
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    // Two-flop synchronisers and edge-history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {sclk_m, sclk_s, sclk_d} <= '0;
            {cs_m, cs_s, cs_d}       <= '0;
            {mosi_m, mosi_s}         <= '0;
            {hold_m, hold_s}         <= 2'b11;
        end else begin
            sclk_m <= sclk_i;  sclk_s <= sclk_m;  sclk_d <= sclk_s;
            cs_m   <= cs_n_i;  cs_s   <= cs_m;    cs_d   <= cs_s;
            mosi_m <= mosi_i;  mosi_s <= mosi_m;
            hold_m <= hold_n_i; hold_s <= hold_m;
        end
    end

    // Arming: select must be seen high after reset, then low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_high <= 1'b0;
            armed     <= 1'b0;
        end else begin
            seen_high <= seen_high | cs_s;
            armed     <= armed | (seen_high & ~cs_s);
        end
    end

    // Input shifter and bit counter, cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (active && sclk_rise) begin
            rx_sr   <= {rx_sr[5:0], mosi_s};
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

    // Byte and frame-end event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_valid  <= 1'b0;
            rx_byte     <= '0;
            frame_end   <= 1'b0;
            end_aligned <= 1'b0;
        end else begin
            byte_valid  <= active & sclk_rise & (bit_cnt == 3'd7);
            rx_byte     <= {rx_sr, mosi_s};
            frame_end   <= armed & cs_s & ~cs_d;
            end_aligned <= (bit_cnt == 3'd0);
        end
    end

    // Output bit on falling edges and output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso    <= 1'b0;
            miso_oe <= 1'b0;
        end else begin
            if (active && sclk_fall) miso <= tx_byte[~bit_cnt];
            miso_oe <= active;
        end
    end

    assert_oe_off_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso_oe);
    assert_locked_until_armed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !byte_valid);
    assert_hold_pause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> (!byte_valid && !miso_oe));
endmodule

// File: rtl/spi_flash_cmd.sv
// Command decoder. Takes opcode and address bytes and collects program data
// in a page buffer. Picks the byte to send back. Issues one-cycle program
// and erase requests at a byte-aligned frame end.
// Assumes PAGE_BYTES is a power of two, at least 2, and AW <= 24.
module spi_flash_cmd
    import spi_flash_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int AW         = 7,
    localparam int OFFW      = $clog2(PAGE_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_valid,
    input  logic [7:0]                 rx_byte,
    input  logic                       frame_end,
    input  logic                       end_aligned,
    input  logic                       busy,
    input  logic [7:0]                 rd_data,
    output logic [7:0]                 tx_byte,
    output logic [AW-1:0]              cur_addr,
    output logic                       op_prog,
    output logic                       op_serase,
    output logic                       op_berase,
    output logic [PAGE_BYTES-1:0][7:0] pg_data,
    output logic [PAGE_BYTES-1:0]      pg_mask
);
    cmd_state_t state;
    logic [7:0] opcode;
    logic [1:0] addr_cnt;
    logic       got_data;

    // Byte sent back: memory in read, status in status read, else all ones.
    always_comb begin
        case (state)
            ST_READ:   tx_byte = rd_data;
            ST_STATUS: tx_byte = {7'b0, busy};
            default:   tx_byte = 8'hFF;
        endcase
    end

    // Command sequencing, address build-up, page buffer and commit requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OPCODE;
            opcode    <= '0;
            addr_cnt  <= '0;
            got_data  <= 1'b0;
            cur_addr  <= '0;
            op_prog   <= 1'b0;
            op_serase <= 1'b0;
            op_berase <= 1'b0;
            pg_data   <= '0;
            pg_mask   <= '0;
        end else begin
            op_prog   <= 1'b0;
            op_serase <= 1'b0;
            op_berase <= 1'b0;
            if (frame_end) begin
                if (end_aligned) begin
                    if (state == ST_PROG && got_data) op_prog <= 1'b1;
                    if (state == ST_ERASE_END) begin
                        if (opcode == OPC_SERASE) op_serase <= 1'b1;
                        else                      op_berase <= 1'b1;
                    end
                end
                state    <= ST_OPCODE;
                addr_cnt <= '0;
            end else if (byte_valid) begin
                case (state)
                    ST_OPCODE: begin
                        opcode <= rx_byte;
                        case (rx_byte)
                            OPC_READ:   state <= ST_ADDR;
                            OPC_STATUS: state <= ST_STATUS;
                            OPC_PROG: begin
                                state    <= busy ? ST_DISCARD : ST_ADDR;
                                pg_mask  <= '0;
                                got_data <= 1'b0;
                            end
                            OPC_SERASE: state <= busy ? ST_DISCARD : ST_ADDR;
                            OPC_BERASE: state <= busy ? ST_DISCARD : ST_ERASE_END;
                            default:    state <= ST_DISCARD;
                        endcase
                    end
                    ST_ADDR: begin
                        cur_addr <= AW'({cur_addr, rx_byte});
                        addr_cnt <= addr_cnt + 2'd1;
                        if (addr_cnt == 2'd2) begin
                            if (opcode == OPC_READ)      state <= ST_READ;
                            else if (opcode == OPC_PROG) state <= ST_PROG;
                            else                         state <= ST_ERASE_END;
                        end
                    end
                    ST_READ: cur_addr <= cur_addr + AW'(1);
                    ST_PROG: begin
                        pg_data[cur_addr[OFFW-1:0]] <= rx_byte;
                        pg_mask[cur_addr[OFFW-1:0]] <= 1'b1;
                        got_data                    <= 1'b1;
                        cur_addr[OFFW-1:0]          <= cur_addr[OFFW-1:0] + OFFW'(1);
                    end
                    ST_ERASE_END: state <= ST_DISCARD;
                    default: ;
                endcase
            end
        end
    end

    assert_commit_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_prog || op_serase || op_berase) |-> $past(frame_end && end_aligned));
    assert_prog_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_prog |-> (pg_mask != '0));
    assert_discard_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISCARD && !frame_end) |=> (state == ST_DISCARD || state == ST_OPCODE));
endmodule

// File: rtl/spi_flash_array.sv
// Storage array and busy timer. Register memory laid out in pages and
// sectors. Applies an AND-program of one page, a sector fill or a full
// fill with ones. Busy counts BUSY_CYCLES clocks after each operation.
// Assumes SECTORS >= 2, BUSY_CYCLES >= 1 and at most one request per cycle.
module spi_flash_array #(
    parameter int PAGE_BYTES       = 16,
    parameter int PAGES_PER_SECTOR = 4,
    parameter int SECTORS          = 2,
    parameter int BUSY_CYCLES      = 200,
    localparam int SECTOR_BYTES    = PAGE_BYTES * PAGES_PER_SECTOR,
    localparam int DEPTH           = SECTOR_BYTES * SECTORS,
    localparam int AW              = $clog2(DEPTH),
    localparam int OFFW            = $clog2(PAGE_BYTES),
    localparam int SECLSB          = $clog2(SECTOR_BYTES),
    localparam int CW              = $clog2(BUSY_CYCLES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_prog,
    input  logic                       op_serase,
    input  logic                       op_berase,
    input  logic [AW-1:0]              op_addr,
    input  logic [PAGE_BYTES-1:0][7:0] pg_data,
    input  logic [PAGE_BYTES-1:0]      pg_mask,
    input  logic [AW-1:0]              rd_addr,
    output logic [7:0]                 rd_data,
    output logic                       busy
);
    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] busy_cnt;

    assign rd_data = mem[rd_addr];
    assign busy    = (busy_cnt != '0);

    // Memory update: reset and erase fill with ones, program ANDs one page.
    always_ff @(posedge clk) begin
        if (!rst_n || op_berase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (op_serase) begin
            for (int i = 0; i < DEPTH; i++)
                if ((AW'(i) >> SECLSB) == (op_addr >> SECLSB)) mem[i] <= 8'hFF;
        end else if (op_prog) begin
            for (int j = 0; j < PAGE_BYTES; j++)
                if (pg_mask[j])
                    mem[{op_addr[AW-1:OFFW], OFFW'(j)}] <=
                        mem[{op_addr[AW-1:OFFW], OFFW'(j)}] & pg_data[j];
        end
    end

    // Busy timer standing in for program and erase time.
    always_ff @(posedge clk) begin
        if (!rst_n)                             busy_cnt <= '0;
        else if (op_prog || op_serase || op_berase) busy_cnt <= CW'(BUSY_CYCLES);
        else if (busy_cnt != '0)                busy_cnt <= busy_cnt - CW'(1);
    end

    assert_no_op_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(op_prog || op_serase || op_berase));
    assert_op_sets_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_prog || op_serase || op_berase) |=> busy);
    assert_bulk_fills_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_berase |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));
endmodule

// File: rtl/spi_flash_slave.sv
// Top level of the serial flash front end: bit engine, command decoder and
// storage array. Assumes SPI mode 0 and a serial clock below clk/4.
module spi_flash_slave #(
    parameter int PAGE_BYTES       = 16,
    parameter int PAGES_PER_SECTOR = 4,
    parameter int SECTORS          = 2,
    parameter int BUSY_CYCLES      = 200,
    localparam int DEPTH           = PAGE_BYTES * PAGES_PER_SECTOR * SECTORS,
    localparam int AW              = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    input  logic spi_hold_n,
    output logic spi_miso,
    output logic spi_miso_oe
);
    logic                       byte_valid, frame_end, end_aligned, busy;
    logic [7:0]                 rx_byte, tx_byte, rd_data;
    logic [AW-1:0]              cur_addr;
    logic                       op_prog, op_serase, op_berase;
    logic [PAGE_BYTES-1:0][7:0] pg_data;
    logic [PAGE_BYTES-1:0]      pg_mask;

    spi_flash_bitio i_bitio (
        .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n),
        .mosi_i(spi_mosi), .hold_n_i(spi_hold_n), .tx_byte(tx_byte),
        .byte_valid(byte_valid), .rx_byte(rx_byte), .frame_end(frame_end),
        .end_aligned(end_aligned), .miso(spi_miso), .miso_oe(spi_miso_oe)
    );

    spi_flash_cmd #(.PAGE_BYTES(PAGE_BYTES), .AW(AW)) i_cmd (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .rx_byte(rx_byte),
        .frame_end(frame_end), .end_aligned(end_aligned), .busy(busy),
        .rd_data(rd_data), .tx_byte(tx_byte), .cur_addr(cur_addr),
        .op_prog(op_prog), .op_serase(op_serase), .op_berase(op_berase),
        .pg_data(pg_data), .pg_mask(pg_mask)
    );

    spi_flash_array #(
        .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_SECTOR(PAGES_PER_SECTOR),
        .SECTORS(SECTORS), .BUSY_CYCLES(BUSY_CYCLES)
    ) i_array (
        .clk(clk), .rst_n(rst_n), .op_prog(op_prog), .op_serase(op_serase),
        .op_berase(op_berase), .op_addr(cur_addr), .pg_data(pg_data),
        .pg_mask(pg_mask), .rd_addr(cur_addr), .rd_data(rd_data), .busy(busy)
    );
endmodule

// File: tb/test_spi_flash_slave.sv
// Bench: directed corner cases mixed with seeded random programs and reads,
// checked against a bench-side model of the memory.
module test_spi_flash_slave;
    localparam int PB    = 16;
    localparam int SECB  = PB * 4;
    localparam int DEPTH = SECB * 2;
    localparam int BUSYC = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b0, mosi = 1'b0, hold_n = 1'b1;
    logic miso, miso_oe;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;
    logic [7:0] mem_m [DEPTH];
    logic [7:0] dq [40];

    always #4 clk = ~clk;

    spi_flash_slave #(.BUSY_CYCLES(BUSYC)) i_spi_flash_slave (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (5) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            half();
            rx[i] = miso;
            sclk = 1'b1;
            half();
            sclk = 1'b0;
        end
    endtask

    task automatic bits(input int k);
        for (int i = 0; i < k; i++) begin
            mosi = 1'b0; half(); sclk = 1'b1; half(); sclk = 1'b0;
        end
    endtask

    task automatic open_f();
        cs_n = 1'b0; half();
    endtask

    task automatic close_f();
        half(); cs_n = 1'b1; half(); half();
    endtask

    task automatic send_addr(input int a);
        logic [7:0] r;
        xfer(8'(a >> 16), r); xfer(8'(a >> 8), r); xfer(8'(a), r);
    endtask

    task automatic do_status(output logic [7:0] st);
        logic [7:0] r;
        open_f(); xfer(8'h05, r); xfer(8'h00, st); close_f();
    endtask

    task automatic wait_idle();
        logic [7:0] st;
        int n = 0;
        do begin do_status(st); n++; end while (st[0] && n < 12);
        check(st == 8'h00, "R9 busy clears", st, 8'h00);
    endtask

    task automatic do_read(input int a, input int n, input string req);
        logic [7:0] r;
        open_f(); xfer(8'h03, r); send_addr(a);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r);
            check(r === mem_m[(a + k) % DEPTH], req, r, mem_m[(a + k) % DEPTH]);
        end
        close_f();
    endtask

    // Program n bytes from dq; extra partial bits cancel; model applied if apply.
    task automatic do_prog(input int a, input int n, input int extra, input bit apply);
        logic [7:0] r;
        logic [7:0] pbuf [PB];
        bit         pm [PB];
        int         base = (a / PB) * PB;
        for (int j = 0; j < PB; j++) pm[j] = 1'b0;
        open_f(); xfer(8'h02, r); send_addr(a);
        for (int k = 0; k < n; k++) begin
            xfer(dq[k], r);
            pbuf[(a + k) % PB] = dq[k];
            pm[(a + k) % PB] = 1'b1;
        end
        bits(extra);
        close_f();
        if (apply && extra == 0 && n > 0)
            for (int j = 0; j < PB; j++)
                if (pm[j]) mem_m[base + j] = mem_m[base + j] & pbuf[j];
    endtask

    task automatic fill_dq(input int n);
        for (int k = 0; k < n; k++) dq[k] = 8'($urandom);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] r, st;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(miso_oe == 1'b0, "R2 reset output off", miso_oe, 0);

        // R1: select low since reset, a program frame must be ignored.
        xfer(8'h02, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r);
        xfer(8'h00, r);
        check(miso_oe == 1'b0, "R1 unarmed output off", miso_oe, 0);
        close_f();
        check(miso_oe == 1'b0, "R2 deselected output off", miso_oe, 0);
        do_read(0, 2, "R1 unarmed program ignored");

        // R4 status idle; R2 output enabled while selected.
        open_f(); xfer(8'h05, r); xfer(8'h00, st);
        check(miso_oe == 1'b1, "R2 selected output on", miso_oe, 1);
        xfer(8'h00, r);
        check(st == 8'h00 && r == 8'h00, "R4 idle status", {st, r}, 16'h0000);
        close_f();

        // R5 program, busy, and R9 second program ignored while busy.
        dq[0] = 8'hA5; dq[1] = 8'h3C;
        do_prog(5, 2, 0, 1'b1);
        do_status(st);
        check(st == 8'h01, "R9 busy after commit, R4 bits 7:1 zero", st, 8'h01);
        dq[0] = 8'h00; dq[1] = 8'h00;
        do_prog(5, 2, 0, 1'b0);
        wait_idle();
        do_read(4, 4, "R9 program while busy ignored");

        // R5 wrap within page, doubled offset takes later byte, AND rule.
        fill_dq(PB + 3);
        do_prog(PB * 2 + 10, PB + 3, 0, 1'b1);
        wait_idle();
        do_read(PB * 2, PB + 2, "R5 page wrap and AND");

        // R8 unaligned program end cancels.
        fill_dq(3); dq[0] = 8'h00;
        do_prog(PB * 5, 3, 5, 1'b0);
        do_status(st);
        check(st == 8'h00, "R8 unaligned program not started", st, 8'h00);
        do_read(PB * 5, 3, "R8 unaligned program ignored");

        // R10 unknown opcode then program bytes in same frame.
        open_f(); xfer(8'h5A, r); xfer(8'h02, r); send_addr(PB * 5); xfer(8'h00, r);
        close_f();
        do_read(PB * 5, 1, "R10 unknown opcode ignored");

        // R11 hold in the middle of the address.
        dq[0] = 8'h0F; do_prog(PB * 6 + 1, 1, 0, 1'b1); wait_idle();
        open_f(); xfer(8'h03, r); xfer(8'h00, r);
        hold_n = 1'b0; half();
        for (int i = 0; i < 8; i++) begin
            mosi = 1'($urandom); half(); sclk = 1'b1; half(); sclk = 1'b0;
        end
        check(miso_oe == 1'b0, "R11 output off on hold", miso_oe, 0);
        hold_n = 1'b1; half();
        xfer(8'h00, r); xfer(8'(PB * 6), r);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, r);
            check(r === mem_m[PB * 6 + k], "R11 read resumes after hold", r, mem_m[PB * 6 + k]);
        end
        close_f();

        // Random programs and reads (R5, R3).
        for (int it = 0; it < 8; it++) begin
            int a = int'($urandom % DEPTH);
            int n = 1 + int'($urandom % (PB + 4));
            fill_dq(n);
            do_prog(a, n, 0, 1'b1);
            wait_idle();
            do_read(int'($urandom % DEPTH), 1 + int'($urandom % 12), "R3 random read after R5 program");
        end

        // R3 read crossing the top of the array.
        do_read(DEPTH - 3, 6, "R3 read wraps at array end");

        // R8 erase followed by an extra byte cancels.
        open_f(); xfer(8'hD8, r); send_addr(SECB); xfer(8'h00, r); close_f();
        do_status(st);
        check(st == 8'h00, "R8 erase with extra byte not started", st, 8'h00);

        // R6 sector erase of the upper sector.
        open_f(); xfer(8'hD8, r); send_addr(SECB + 7); close_f();
        for (int i = SECB; i < DEPTH; i++) mem_m[i] = 8'hFF;
        wait_idle();
        do_read(SECB - 4, 8, "R6 sector erase boundary");

        // R7 bulk erase.
        open_f(); xfer(8'hC7, r); close_f();
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
        wait_idle();
        do_read(0, DEPTH, "R7 bulk erase all ones");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule